// File: doc/BRIEF.md
# Converter Fault Supervisor

This block is the synchronous protection controller of a step-down converter. Each clock it takes in the feedback window comparator flags, the lockout flags of both supply rails, an 8-bit die temperature code, a latched over-current request and a flag that shows the soft-start ramp has reached the feedback voltage. From these it sets the high-side and low-side gate enables, a fault-latched status and a power-good inhibit. PWM generation, the comparators, power-good deglitching and the over-current event counter sit outside the block.

The over-voltage and under-voltage flags count as faults only after they stay high for a blanking time. Each flag has its own blanking time, given in clock cycles by a parameter. Supply lockout and over-temperature clear by themselves, and the converter then restarts through its soft-start phase. Over-voltage, under-voltage and over-current faults stay latched until a lockout or a reset. An over-voltage fault first pulls the output down through the low-side switch. After that both switches go off.

Top module: `fault_supervisor`

## Requirements
- R1: While `rst` is high, and on the clock edge after either lockout flag is sampled high, the outputs are hs_en=0, ls_en=0, fault_latched=0, pg_inhibit=1.
- R2: One edge after both lockout flags are sampled low, the block enters startup. In startup the outputs are hs_en=1, ls_en=0, fault_latched=0, pg_inhibit=0.
- R3: In startup, ls_en stays 0 until `ss_at_fb` is sampled high. On that edge the block enters run, with hs_en=1 and ls_en=1.
- R4: An over-voltage fault is taken on the edge after `ov_flag` has been sampled high on OV_BLANK_CYC edges in a row while running. Any low sample restarts the count from zero.
- R5: In the over-voltage fault the outputs are hs_en=0, ls_en=1, fault_latched=1, pg_inhibit=1. They stay so until `uv_flag` is sampled high. On that edge both enables drop to 0 and the fault stays latched.
- R6: An under-voltage fault is taken on the edge after `uv_flag` has been sampled high on UV_BLANK_CYC edges in a row while running. It gives hs_en=0, ls_en=0, fault_latched=1.
- R7: A latched fault ignores its clearing flags, the thermal input and the over-current input. Only a lockout or a reset clears it.
- R8: `oc_req` sampled high in startup or run latches a fault, with both enables at 0, on that edge.
- R9: A registered hot state sets when temp_code >= TEMP_TRIP and clears when temp_code <= TEMP_TRIP - TEMP_HYST. Each change reaches the outputs one edge later. Hot gives both enables 0, pg_inhibit=1 and fault_latched=0. Cooling returns the block to startup.
- R10: When causes coincide, the priority is lockout, then thermal, then over-current, then over-voltage, then under-voltage.
- R11: pg_inhibit is 1 in every fault state and in lockout, and 0 in startup and run.
- R12: The blanking counters advance only while running. Flags held high during startup are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ov_flag | input | 1 | Feedback above over-voltage threshold |
| uv_flag | input | 1 | Feedback below under-voltage threshold |
| uvlo_vin | input | 1 | Input rail in lockout |
| uvlo_aux | input | 1 | Bias rail in lockout |
| temp_code | input | TEMP_W | Die temperature code |
| oc_req | input | 1 | Latched over-current fault request |
| ss_at_fb | input | 1 | Soft-start ramp has reached feedback |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |
| fault_latched | output | 1 | A latched fault is active |
| pg_inhibit | output | 1 | Forces power-good low |

## Verification
On every cycle the assertions check the lockout response, the pre-bias hold of the low-side enable, the discharge hold and the persistence of latched faults. They also check that a blanking trip is always preceded by its flag being high and that the hot state changes only across its thresholds. The exact edge on which a blanking count expires, the reset of a count by a one-cycle gap, the thermal hysteresis points, and the priority when several causes occur together are shown only by the bench's scenarios.

// File: rtl/fsup_pkg.sv
`timescale 1ns/1ps
package fsup_pkg;

  typedef enum logic [2:0] {
    ST_LOCK, ST_START, ST_RUN, ST_THERM, ST_OC, ST_OVDIS, ST_HIZ, ST_UV
  } fsup_state_e;

  typedef struct packed {
    logic hs;
    logic ls;
    logic lat;
    logic pgi;
  } fsup_drive_t;

  function automatic fsup_drive_t drive_of(input fsup_state_e s);
    case (s)
      ST_START:            return fsup_drive_t'(4'b1000);
      ST_RUN:              return fsup_drive_t'(4'b1100);
      ST_OVDIS:            return fsup_drive_t'(4'b0111);
      ST_OC, ST_HIZ, ST_UV: return fsup_drive_t'(4'b0011);
      default:             return fsup_drive_t'(4'b0001);
    endcase
  endfunction

endpackage

// File: rtl/fsup_blank.sv
`timescale 1ns/1ps
module fsup_blank #(
  parameter int unsigned LIMIT = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic flag,
  output logic trip
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM_L = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr || !flag) cnt_q <= '0;
    else if (cnt_q != LIM_L) cnt_q <= cnt_q + 1'b1;
  end

  assign trip = (cnt_q == LIM_L);

  // R4 (also R6): a trip is only possible right after a high flag sample
  blank_hold_chk: assert property (@(posedge clk) disable iff (rst || clr)
    trip |-> $past(flag));

endmodule

// File: rtl/fsup_thermal.sv
`timescale 1ns/1ps
module fsup_thermal #(
  parameter int TW        = 8,
  parameter int unsigned TRIP = 200,
  parameter int unsigned HYST = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] temp_i,
  output logic          hot_o
);
  localparam logic [TW-1:0] TRIP_L = TW'(TRIP);
  localparam logic [TW-1:0] CLR_L  = TW'(TRIP - HYST);

  always_ff @(posedge clk) begin
    if (rst) hot_o <= 1'b0;
    else if (temp_i >= TRIP_L) hot_o <= 1'b1;
    else if (temp_i <= CLR_L) hot_o <= 1'b0;
  end

  // R9
  hot_set_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hot_o) |-> ($past(temp_i) >= TRIP_L));
  // R9
  hot_clr_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(hot_o) |-> ($past(temp_i) <= CLR_L));

endmodule

// File: rtl/fsup_ctrl.sv
`timescale 1ns/1ps
module fsup_ctrl
  import fsup_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic lock_i,
  input  logic hot_i,
  input  logic oc_i,
  input  logic ov_trip_i,
  input  logic uv_trip_i,
  input  logic uv_i,
  input  logic ss_i,
  output logic run_o,
  output logic hs_en_o,
  output logic ls_en_o,
  output logic lat_o,
  output logic pg_inh_o
);
  fsup_state_e st_q, st_d;
  fsup_drive_t drv_d;

  always_comb begin
    st_d = st_q;
    if (lock_i) begin
      st_d = ST_LOCK;
    end else begin
      case (st_q)
        ST_LOCK, ST_START, ST_RUN: begin
          if (hot_i)                         st_d = ST_THERM;
          else if (oc_i)                     st_d = ST_OC;
          else if (st_q == ST_RUN && ov_trip_i) st_d = ST_OVDIS;
          else if (st_q == ST_RUN && uv_trip_i) st_d = ST_UV;
          else if (st_q == ST_LOCK)          st_d = ST_START;
          else if (st_q == ST_START && ss_i) st_d = ST_RUN;
        end
        ST_THERM: if (!hot_i) st_d = ST_START;
        ST_OVDIS: if (uv_i)   st_d = ST_HIZ;
        default:  st_d = st_q;
      endcase
    end
  end

  assign drv_d = drive_of(st_d);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_LOCK;
      hs_en_o  <= 1'b0;
      ls_en_o  <= 1'b0;
      lat_o    <= 1'b0;
      pg_inh_o <= 1'b1;
    end else begin
      st_q     <= st_d;
      hs_en_o  <= drv_d.hs;
      ls_en_o  <= drv_d.ls;
      lat_o    <= drv_d.lat;
      pg_inh_o <= drv_d.pgi;
    end
  end

  assign run_o = (st_q == ST_RUN);

  // R1
  lock_off_chk: assert property (@(posedge clk) disable iff (rst)
    lock_i |=> (!hs_en_o && !ls_en_o && pg_inh_o && !lat_o));
  // R3
  prebias_chk: assert property (@(posedge clk) disable iff (rst)
    (hs_en_o && !ls_en_o && !ss_i) |=> !ls_en_o);
  // R7
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (lat_o && !lock_i) |=> lat_o);
  // R5
  discharge_chk: assert property (@(posedge clk) disable iff (rst)
    (lat_o && ls_en_o && !uv_i && !lock_i) |=> (ls_en_o && !hs_en_o));

endmodule

// File: rtl/fault_supervisor.sv
`timescale 1ns/1ps
module fault_supervisor #(
  parameter int unsigned OV_BLANK_CYC = 17000,
  parameter int unsigned UV_BLANK_CYC = 65000,
  parameter int          TEMP_W       = 8,
  parameter int unsigned TEMP_TRIP    = 200,
  parameter int unsigned TEMP_HYST    = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ov_flag,
  input  logic              uv_flag,
  input  logic              uvlo_vin,
  input  logic              uvlo_aux,
  input  logic [TEMP_W-1:0] temp_code,
  input  logic              oc_req,
  input  logic              ss_at_fb,
  output logic              hs_en,
  output logic              ls_en,
  output logic              fault_latched,
  output logic              pg_inhibit
);
  logic run, cnt_clr, ov_trip, uv_trip, hot, lock;

  assign lock    = uvlo_vin | uvlo_aux;
  assign cnt_clr = ~run;

  fsup_blank #(.LIMIT(OV_BLANK_CYC)) ov_blank_i (
    .clk(clk), .rst(rst), .clr(cnt_clr), .flag(ov_flag), .trip(ov_trip));

  fsup_blank #(.LIMIT(UV_BLANK_CYC)) uv_blank_i (
    .clk(clk), .rst(rst), .clr(cnt_clr), .flag(uv_flag), .trip(uv_trip));

  fsup_thermal #(.TW(TEMP_W), .TRIP(TEMP_TRIP), .HYST(TEMP_HYST)) therm_i (
    .clk(clk), .rst(rst), .temp_i(temp_code), .hot_o(hot));

  fsup_ctrl ctrl_i (
    .clk(clk), .rst(rst), .lock_i(lock), .hot_i(hot), .oc_i(oc_req),
    .ov_trip_i(ov_trip), .uv_trip_i(uv_trip), .uv_i(uv_flag), .ss_i(ss_at_fb),
    .run_o(run), .hs_en_o(hs_en), .ls_en_o(ls_en), .lat_o(fault_latched),
    .pg_inh_o(pg_inhibit));

endmodule

// File: tb/fault_supervisor_tb_top.sv
`timescale 1ns/1ps
module fault_supervisor_tb_top;
  localparam int OVB = 6;
  localparam int UVB = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ov = 1'b0, uv = 1'b0, uvv = 1'b0, uva = 1'b0, oc = 1'b0, ss = 1'b0;
  logic [7:0] temp = 8'd50;
  logic hs_en, ls_en, fault_latched, pg_inhibit;
  int nchk = 0;
  int nerr = 0;

  always #4 clk = ~clk;

  fault_supervisor #(.OV_BLANK_CYC(OVB), .UV_BLANK_CYC(UVB), .TEMP_W(8),
                     .TEMP_TRIP(200), .TEMP_HYST(20)) dut_i (
    .clk(clk), .rst(rst), .ov_flag(ov), .uv_flag(uv), .uvlo_vin(uvv),
    .uvlo_aux(uva), .temp_code(temp), .oc_req(oc), .ss_at_fb(ss),
    .hs_en(hs_en), .ls_en(ls_en), .fault_latched(fault_latched),
    .pg_inhibit(pg_inhibit));

  // {uvlo_vin, uvlo_aux, ov, uv, oc, ss}, temp, expected {hs, ls, latched, pg_inhibit}
  localparam logic [17:0] VEC [19] = '{
    {6'b100000, 8'd50,  4'b0001},
    {6'b000000, 8'd50,  4'b1000},
    {6'b000000, 8'd50,  4'b1000},
    {6'b000001, 8'd50,  4'b1100},
    {6'b000000, 8'd50,  4'b1100},
    {6'b000000, 8'd200, 4'b1100},
    {6'b000000, 8'd200, 4'b0001},
    {6'b000000, 8'd181, 4'b0001},
    {6'b000000, 8'd180, 4'b0001},
    {6'b000000, 8'd180, 4'b1000},
    {6'b000001, 8'd50,  4'b1100},
    {6'b010001, 8'd50,  4'b0001},
    {6'b000001, 8'd50,  4'b1000},
    {6'b000001, 8'd50,  4'b1100},
    {6'b000011, 8'd50,  4'b0011},
    {6'b000000, 8'd255, 4'b0011},
    {6'b000000, 8'd50,  4'b0011},
    {6'b100000, 8'd50,  4'b0001},
    {6'b000000, 8'd50,  4'b1000}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic [3:0] exp, input string req);
    logic [3:0] act;
    act = {hs_en, ls_en, fault_latched, pg_inhibit};
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got hs/ls/lat/pgi=%b expected %b", req, act, exp);
    end
  endtask

  task automatic go_run();
    uvv = 1'b1; tick(1); chk(4'b0001, "R1 lockout clears latch R7");
    uvv = 1'b0; ov = 1'b0; uv = 1'b0; oc = 1'b0; ss = 1'b1;
    tick(1); chk(4'b1000, "R2 restart");
    tick(1); chk(4'b1100, "R3 run");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    tick(3);
    chk(4'b0001, "R1 reset state");
    rst = 1'b0;

    for (int i = 0; i < 19; i++) begin
      {uvv, uva, ov, uv, oc, ss} = VEC[i][17:12];
      temp = VEC[i][11:4];
      tick(1);
      chk(VEC[i][3:0], $sformatf("table step %0d R1 R2 R3 R8 R9 R11", i));
    end

    ss = 1'b1; tick(1); chk(4'b1100, "R3 enter run");
    // R4 blanking with a gap restarting the count
    ov = 1'b1; tick(OVB - 1); chk(4'b1100, "R4 short ov");
    ov = 1'b0; tick(1);
    ov = 1'b1; tick(OVB);     chk(4'b1100, "R4 count just complete");
    tick(1);                  chk(4'b0111, "R5 discharge R11");
    ov = 1'b0; tick(3);       chk(4'b0111, "R5 discharge hold");
    uv = 1'b1; tick(1);       chk(4'b0011, "R5 high impedance");
    uv = 1'b0; tick(3);       chk(4'b0011, "R7 latched hold");

    // R12: flags during startup are not counted
    uvv = 1'b1; tick(1); chk(4'b0001, "R7 lockout clears");
    uvv = 1'b0; ss = 1'b0; tick(1); chk(4'b1000, "R2 startup");
    ov = 1'b1; tick(OVB + 3); chk(4'b1000, "R12 R3 ov ignored in startup");
    ov = 1'b0; ss = 1'b1; tick(1); chk(4'b1100, "R3 run after ss");

    // R6 under-voltage
    uv = 1'b1; tick(UVB); chk(4'b1100, "R6 count just complete");
    tick(1);              chk(4'b0011, "R6 uv fault");
    uv = 1'b0; tick(2);   chk(4'b0011, "R7 uv latched");

    // R10 lockout over thermal and OC, thermal over OC
    uvv = 1'b1; oc = 1'b1; temp = 8'd220;
    tick(1); chk(4'b0001, "R10 lockout first");
    tick(1); chk(4'b0001, "R1 lockout held");
    uvv = 1'b0; tick(1); chk(4'b0001, "R10 thermal over oc");
    temp = 8'd100; tick(1); chk(4'b0001, "R9 hot one more edge");
    tick(1); chk(4'b1000, "R9 restart after cooling");
    tick(1); chk(4'b0011, "R8 oc latch");
    oc = 1'b0;

    // R10 OC over OV
    go_run();
    ov = 1'b1; tick(OVB); chk(4'b1100, "R4 ov ready");
    oc = 1'b1; tick(1);   chk(4'b0011, "R10 oc over ov");
    oc = 1'b0; ov = 1'b0;

    // R10 OV over UV
    go_run();
    uv = 1'b1; tick(UVB - OVB);
    ov = 1'b1; tick(OVB); chk(4'b1100, "R10 both ready");
    tick(1);              chk(4'b0111, "R10 ov over uv");

    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule